// File: doc/BRIEF.md
# Disk Word-Done Wakeup Synchronizer

This block sits between a disk drive's read bit clock and the processor's system clock. On the drive side it counts bit clocks, and when a 16-bit word is complete it raises a word-done flag. That flag is carried into the system clock domain through a multi-stage synchronizer and becomes a wakeup request for the disk word task. A return path, with its own synchronizer, takes the captured flag back to the drive domain so that the flag can be cleared there.

A single allow bit gates the whole block. The allow bit is written by a load-command strobe that the instruction decoder produces. While allow is low, the bit counter, the flags and the wakeup request are all held cleared. The init status bit is also held on, so that it marks the first pass of the word task. Once allow is high, init goes off as soon as the word task blocks during its execution.

Top module: `disk_word_wake`

## Requirements
- R1: After reset, allow is 0. On a system clock edge where `cmd_load` is 1, allow takes the value of `cmd_allow`. Otherwise allow holds its value.
- R2: While allow is 0, `wake_req` is 0 and stays 0 whatever the drive clock does. Any bits already counted toward a word are discarded, so each word after allow returns needs a full count.
- R3: `init_stat` is 1 after reset, and 1 on every system edge that follows a cycle with allow at 0.
- R4: While allow is 1, `init_stat` clears on the system edge after a cycle with `task_block` at 1. It then stays 0 until allow goes to 0.
- R5: After allow rises, the first two drive clock edges only release the drive-side reset. Each group of 16 drive edges after that completes one word. A group of 15 edges produces no wakeup, and the 16th edge does.
- R6: `wake_req` rises two system edges after the word-done flag is captured in the first synchronizer stage. It stays at 1 until `task_ack` is sampled at 1, and falls on that edge.
- R7: Each completed word produces exactly one rising edge of `wake_req`, with no loss and no duplicate, even when words arrive back to back. This holds as long as the system clock is at least as fast as the drive clock.
- R8: The drive-side word-done flag stays set until the return handshake from the system domain reaches the drive domain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | System clock |
| sys_rst_n | input | 1 | Asynchronous active-low reset, system domain |
| bit_clk | input | 1 | Read bit clock from the drive |
| cmd_load | input | 1 | Load-command strobe decoded from an instruction |
| cmd_allow | input | 1 | Value that the strobe loads into the allow bit |
| task_block | input | 1 | Word task is blocking during its execution |
| task_ack | input | 1 | Word task accepts the wakeup request |
| wake_req | output | 1 | Wakeup request to the word task |
| init_stat | output | 1 | Init status: first pass of the word task |

## Verification
The block is driven with these drive-clock patterns:
- A single word separates correct counting from an off-by-one in the 16 count.
- A run of 15 edges followed by one more pins the exact boundary.
- A burst of back-to-back words, running on a drive clock unrelated to the system clock, shows whether the handshake drops or repeats an event when flags follow closely.
- Dropping allow in the middle of a word, and then counting a full word, tells a true clear apart from a counter that only pauses.

The wakeup request is also held without acknowledgement, which shows that it persists and then falls on the acknowledge edge. `task_block` is pulsed both with allow low and with allow high, which separates the forced-on init from the init that clears.

// File: rtl/dww_pkg.sv
`timescale 1ns/1ps
package dww_pkg;
  localparam int unsigned DEF_WORD_BITS   = 16;
  localparam int unsigned DEF_SYNC_STAGES = 2;

  // System-domain control state
  typedef struct packed {
    logic allow;  // transfer enable loaded by the command strobe
    logic init;   // first-invocation status
    logic wake;   // pending wakeup to the word task
    logic seen;   // last synchronized flag level, for edge detection
  } sys_state_t;

  localparam sys_state_t SYS_RESET = '{allow: 1'b0, init: 1'b1, wake: 1'b0, seen: 1'b0};
endpackage

// File: rtl/dww_reset_sync.sv
`timescale 1ns/1ps
module dww_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/dww_sync.sv
`timescale 1ns/1ps
module dww_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  always_comb begin
    if (clr) stg_d = '0;
    else     stg_d = {stg_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/dww_bit_count.sv
`timescale 1ns/1ps
module dww_bit_count #(
  parameter int unsigned WORD_BITS = 16
) (
  input  logic bit_clk,
  input  logic rst_n,
  input  logic ret_seen,  // handshake returned from system domain
  output logic word_end,
  output logic flag
);
  localparam int unsigned CW = (WORD_BITS > 1) ? $clog2(WORD_BITS) : 1;
  localparam logic [CW-1:0] LAST = CW'(WORD_BITS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          flag_q, flag_d;

  always_comb begin
    word_end = (cnt_q == LAST);
    cnt_d    = word_end ? '0 : cnt_q + 1'b1;
    if (word_end)      flag_d = 1'b1;
    else if (ret_seen) flag_d = 1'b0;
    else               flag_d = flag_q;
  end

  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/disk_word_wake.sv
`timescale 1ns/1ps
module disk_word_wake
  import dww_pkg::*;
#(
  parameter int unsigned WORD_BITS   = DEF_WORD_BITS,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic sys_clk,
  input  logic sys_rst_n,
  input  logic bit_clk,
  input  logic cmd_load,
  input  logic cmd_allow,
  input  logic task_block,
  input  logic task_ack,
  output logic wake_req,
  output logic init_stat
);
  sys_state_t st_q, st_d;
  logic bit_arst_n, bit_rst_n;
  logic flag_b, word_end, ret_b, flag_s;

  // Drive-domain reset: asserted while allow is low, released on bit_clk
  assign bit_arst_n = sys_rst_n & st_q.allow;

  dww_reset_sync #(.STAGES(2)) u_bit_rst (
    .clk     (bit_clk),
    .arst_n  (bit_arst_n),
    .rst_n_o (bit_rst_n)
  );

  dww_bit_count #(.WORD_BITS(WORD_BITS)) u_cnt (
    .bit_clk  (bit_clk),
    .rst_n    (bit_rst_n),
    .ret_seen (ret_b),
    .word_end (word_end),
    .flag     (flag_b)
  );

  // Forward: drive flag into system domain
  dww_sync #(.STAGES(SYNC_STAGES)) u_fwd (
    .clk   (sys_clk),
    .rst_n (sys_rst_n),
    .clr   (~st_q.allow),
    .d     (flag_b),
    .q     (flag_s)
  );

  // Return: captured flag back to drive domain
  dww_sync #(.STAGES(SYNC_STAGES)) u_ret (
    .clk   (bit_clk),
    .rst_n (bit_rst_n),
    .clr   (1'b0),
    .d     (flag_s),
    .q     (ret_b)
  );

  always_comb begin
    st_d = st_q;
    if (cmd_load) st_d.allow = cmd_allow;
    if (!st_q.allow) begin
      st_d.init = 1'b1;
      st_d.wake = 1'b0;
      st_d.seen = 1'b0;
    end else begin
      if (task_block) st_d.init = 1'b0;
      st_d.seen = flag_s;
      if (flag_s && !st_q.seen) st_d.wake = 1'b1;
      else if (task_ack)        st_d.wake = 1'b0;
    end
  end

  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) st_q <= SYS_RESET;
    else            st_q <= st_d;
  end

  assign wake_req  = st_q.wake;
  assign init_stat = st_q.init;
endmodule

// File: rtl/dww_checker.sv
`timescale 1ns/1ps
module dww_checker (
  input logic sys_clk,
  input logic sys_rst_n,
  input logic bit_clk,
  input logic bit_rst_n,
  input logic allow,
  input logic cmd_load,
  input logic cmd_allow,
  input logic task_block,
  input logic task_ack,
  input logic wake_req,
  input logic init_stat,
  input logic word_end,
  input logic flag_b,
  input logic ret_b
);
  AST_ALLOW_LOAD: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    cmd_load |=> (allow == $past(cmd_allow)));  // R1
  AST_NO_WAKE_OFF: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    !allow |=> !wake_req);  // R2
  AST_INIT_FORCED: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    !allow |=> init_stat);  // R3
  AST_INIT_CLEARS: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    (allow && task_block) |=> !init_stat);  // R4
  AST_INIT_STAYS: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    (allow && !init_stat) |=> !init_stat);  // R4
  AST_WAKE_HOLD: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    (allow && wake_req && !task_ack) |=> wake_req);  // R6
  AST_FLAG_ON_WORD: assert property (@(posedge bit_clk) disable iff (!bit_rst_n)
    word_end |=> flag_b);  // R5
  AST_FLAG_KEPT: assert property (@(posedge bit_clk) disable iff (!bit_rst_n)
    (flag_b && !ret_b) |=> flag_b);  // R8
endmodule

bind disk_word_wake dww_checker u_chk (
  .sys_clk    (sys_clk),
  .sys_rst_n  (sys_rst_n),
  .bit_clk    (bit_clk),
  .bit_rst_n  (bit_rst_n),
  .allow      (st_q.allow),
  .cmd_load   (cmd_load),
  .cmd_allow  (cmd_allow),
  .task_block (task_block),
  .task_ack   (task_ack),
  .wake_req   (wake_req),
  .init_stat  (init_stat),
  .word_end   (word_end),
  .flag_b     (flag_b),
  .ret_b      (ret_b)
);

// File: tb/sim_disk_word_wake.sv
`timescale 1ns/1ps
module sim_disk_word_wake;
  logic sys_clk = 1'b0;
  logic sys_rst_n = 1'b0;
  logic bit_clk = 1'b0;
  logic cmd_load = 1'b0, cmd_allow = 1'b0, task_block = 1'b0, task_ack = 1'b0;
  logic wake_req, init_stat;

  int checks = 0, errors = 0;
  int exp_q[$];
  int next_id = 0, got_id = 0;
  bit auto_ack = 1'b1;
  bit wake_prev = 1'b0;
  bit done = 1'b0;

  always #4 sys_clk = ~sys_clk;  // 125 MHz

  disk_word_wake u0 (
    .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .bit_clk(bit_clk),
    .cmd_load(cmd_load), .cmd_allow(cmd_allow), .task_block(task_block),
    .task_ack(task_ack), .wake_req(wake_req), .init_stat(init_stat)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bit_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      #6.5 bit_clk = 1'b1;
      #6.5 bit_clk = 1'b0;
    end
  endtask

  // Driver: expected wakeups pushed into the scoreboard
  task automatic send_words(input int n);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(next_id);
      next_id++;
    end
    bit_pulses(16 * n);
  endtask

  task automatic set_allow(input bit v);
    @(negedge sys_clk);
    cmd_load = 1'b1; cmd_allow = v;
    @(negedge sys_clk);
    cmd_load = 1'b0; cmd_allow = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge sys_clk);
  endtask

  // Monitor: pops one expected item per rising wake_req
  initial begin
    forever begin
      @(negedge sys_clk);
      if (wake_req && !wake_prev) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 duplicate wakeup", got_id, -1);
        end else begin
          int e;
          e = exp_q.pop_front();
          check(e == got_id, "R7 wakeup order", got_id, e);
        end
        got_id++;
      end
      task_ack = (wake_req && auto_ack && !task_ack);
      wake_prev = wake_req;
    end
  end

  initial begin
    repeat (200000) @(posedge sys_clk);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle(3);
    sys_rst_n = 1'b1;
    idle(2);
    // R1/R3 reset state
    check(wake_req == 1'b0, "R1 reset wake", wake_req, 0);
    check(init_stat == 1'b1, "R3 reset init", init_stat, 1);

    // R2: drive clock with allow low gives nothing; block with allow low keeps init
    task_block = 1'b1;
    bit_pulses(40);
    idle(10);
    task_block = 1'b0;
    check(got_id == 0, "R2 no wake when disallowed", got_id, 0);
    check(init_stat == 1'b1, "R3 init held while allow low", init_stat, 1);

    // R1: enable, init still on until block
    set_allow(1'b1);
    idle(2);
    check(init_stat == 1'b1, "R4 init before block", init_stat, 1);
    task_block = 1'b1;
    @(negedge sys_clk);
    task_block = 1'b0;
    check(init_stat == 1'b0, "R4 init clears on block", init_stat, 0);
    idle(5);
    check(init_stat == 1'b0, "R4 init stays clear", init_stat, 0);

    // R5: two priming edges, then one word
    bit_pulses(2);
    send_words(1);
    idle(12);
    check(exp_q.size() == 0 && got_id == 1, "R5 single word", got_id, 1);

    // R5: 15 edges give nothing, 16th gives a wakeup
    bit_pulses(15);
    idle(12);
    check(got_id == 1, "R5 fifteen edges no wake", got_id, 1);
    exp_q.push_back(next_id); next_id++;
    bit_pulses(1);
    idle(12);
    check(got_id == 2, "R5 sixteenth edge wakes", got_id, 2);

    // R7/R8: back-to-back burst
    send_words(6);
    idle(15);
    check(exp_q.size() == 0, "R7 burst none lost", exp_q.size(), 0);
    check(got_id == 8, "R8 burst count", got_id, 8);

    // R6: wakeup holds without ack, falls after ack
    auto_ack = 1'b0;
    send_words(1);
    idle(20);
    check(wake_req == 1'b1, "R6 wake held without ack", wake_req, 1);
    auto_ack = 1'b1;
    idle(2);
    check(wake_req == 1'b0, "R6 wake falls after ack", wake_req, 0);

    // R2/R3: drop allow mid-word, partial count discarded
    bit_pulses(10);
    set_allow(1'b0);
    idle(2);
    check(init_stat == 1'b1, "R3 init forced on allow drop", init_stat, 1);
    bit_pulses(20);
    idle(10);
    check(got_id == 9 && wake_req == 1'b0, "R2 no wake after drop", got_id, 9);
    set_allow(1'b1);
    idle(2);
    bit_pulses(2);
    bit_pulses(6);
    idle(12);
    check(got_id == 9, "R2 partial word discarded", got_id, 9);
    exp_q.push_back(next_id); next_id++;
    bit_pulses(10);
    idle(12);
    check(got_id == 10 && exp_q.size() == 0, "R2 full word after re-enable", got_id, 10);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule